// File: doc/BRIEF.md
# Selectable Sync and Subdivided Trigger Unit

This unit produces the output-update strobe and the input-latch strobe for a fieldbus slave node. One of three trigger sources drives them. The first is a free-running local timer. The second is the passage of a frame carrying data for the node. The third is a pulse schedule derived from a 64-bit local time that is kept synchronised elsewhere. In the clock-derived source, the unit emits a slow cycle pulse and a fast sub-pulse. The sub-pulse splits every cycle into `n` equal slots. Each trigger starts two independent delays, one ending in the output strobe and one ending in the input-latch strobe.

Software-style configuration arrives as one write of all fields together. The write is validated first. A rejected write raises an error flag and leaves the timing already in force untouched. The first accepted write after reset takes effect at once and loads the start time of the cycle schedule. Each later accepted write waits until the next cycle boundary. The cycle schedule advances by exactly one cycle length per boundary, so no drift accumulates.

Delays and the free-running timer count system clock cycles. The cycle schedule compares against `local_time`. All strobes and pulses are one system clock cycle wide. With the default parameters, the values are: minimum sub period 8, calculation/copy time 2, output switching time 3, input acquisition time 2, input lead 3.

Top module: `sync_trig_unit`

## Requirements
- R1: After reset, and until the first accepted configuration write, `cyc_pulse`, `sub_pulse`, `out_strobe`, `in_strobe` and `cfg_err` stay low.
- R2: A write with `cfg_sub_ticks` below MIN_SUB, with `cfg_subdiv` = 0, or with `cfg_mode` = 3 is rejected. `cfg_err` is high from the cycle after the write, and the timing in force stays unchanged. An accepted write clears `cfg_err` in the cycle after it.
- R3: A non-zero output shift is accepted only if it is greater than calc+output-switch time and (shift − output-switch time) < `cfg_sub_ticks`. A non-zero input shift is accepted only if it is greater than calc+acquisition time and (shift − acquisition time) < `cfg_sub_ticks`. Any other non-zero shift is rejected as in R2.
- R4: Clock-sync mode is `cfg_mode` = 2. In this mode, `cyc_pulse` is high in the cycle after `local_time` first equals the start time. Later pulses follow at exactly `cfg_sub_ticks`×`cfg_subdiv` local-time steps apart.
- R5: In clock-sync mode, `sub_pulse` is high together with each `cyc_pulse`. It is then high every `cfg_sub_ticks` steps, giving `cfg_subdiv` sub-pulses per cycle.
- R6: With a non-zero output shift S, `out_strobe` is high 1+(S − output-switch time) cycles after the triggering pulse.
- R7: With a non-zero input shift S, `in_strobe` is high 1+(S − acquisition time) cycles after the triggering pulse.
- R8: With a zero output shift, `out_strobe` is high in the cycle after the trigger. With a zero input shift, `in_strobe` is high 1+(MIN_SUB − input lead) cycles after the trigger.
- R9: Frame mode is `cfg_mode` = 1. In this mode, a `frame_evt` cycle with `frame_has_out` = 1 starts both delays from that cycle. With `frame_has_out` = 0 it starts only the input delay.
- R10: Free-run mode is `cfg_mode` = 0. In this mode, both delays are triggered every `cfg_sub_ticks` system clock cycles, with `local_time` having no influence. The first trigger comes 13 cycles after the applying write when the period is 12, since the timer reloads on apply.
- R11: A mode change accepted while a configuration is in force takes effect only at the next cycle boundary. Until then, the old mode keeps control, and frame events are ignored outside frame mode.
- R12: Each strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| local_time | input | 64 | Synchronised local time |
| frame_evt | input | 1 | One-cycle frame passage event |
| frame_has_out | input | 1 | Passing frame carried output data for this node |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | 0 free-run, 1 frame, 2 clock-sync, 3 invalid |
| cfg_sub_ticks | input | 16 | Sub period (free-run period) in ticks |
| cfg_subdiv | input | 4 | Sub-pulses per cycle |
| cfg_start | input | 64 | First cycle start time |
| cfg_out_shift | input | 16 | Output shift, 0 = none |
| cfg_in_shift | input | 16 | Input shift, 0 = none |
| cyc_pulse | output | 1 | Slow cycle pulse |
| sub_pulse | output | 1 | Fast sub-pulse |
| out_strobe | output | 1 | Output update strobe |
| in_strobe | output | 1 | Input latch strobe |
| cfg_err | output | 1 | Last write was rejected |

## Verification
The single-cycle strobe checks rely on two input assumptions. First, triggers never arrive while a delay is still counting. Second, frame events are spaced at least one sub period apart. The stimulus keeps every frame event clear of pending strobes and uses sub periods of at least MIN_SUB, which is above one. The boundary and mode-hold checks rely on `local_time` never moving backwards. The bench therefore only advances it or freezes it.

// File: rtl/stu_pkg.sv
package stu_pkg;
    localparam int TICK_W = 16;
    localparam int DIV_W  = 4;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_FRAME = 2'd1,
        MODE_SYNC  = 2'd2
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e         mode;
        tick_t              sub;
        logic [DIV_W-1:0]   n;
        tick_t              d_out;
        tick_t              d_in;
    } timing_t;

    function automatic logic shift_legal(tick_t sh, tick_t lim, tick_t hw, tick_t sub);
        return (sh == '0) || ((sh > lim) && ((sh - hw) < sub));
    endfunction
endpackage

// File: rtl/stu_delay.sv
module stu_delay
    import stu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trig,
    input  tick_t dly,
    output logic  strobe
);
    tick_t cnt;
    logic  armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            armed  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (trig) begin
                if (dly == '0) begin
                    strobe <= 1'b1;
                    armed  <= 1'b0;
                end else begin
                    cnt   <= dly;
                    armed <= 1'b1;
                end
            end else if (armed) begin
                cnt <= cnt - 1'b1;
                if (cnt == tick_t'(1)) begin
                    strobe <= 1'b1;
                    armed  <= 1'b0;
                end
            end
        end
    end

    assert_strobe_src_R12: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(trig || armed));
    assert_single_R12: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/stu_cfg.sv
module stu_cfg
    import stu_pkg::*;
#(
    parameter int MIN_SUB       = 8,
    parameter int CALC_TICKS    = 2,
    parameter int OUT_HW_TICKS  = 3,
    parameter int IN_HW_TICKS   = 2,
    parameter int IN_LEAD_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       mode_raw,
    input  tick_t            sub,
    input  logic [DIV_W-1:0] n,
    input  tick_t            out_shift,
    input  tick_t            in_shift,
    input  logic             bnd,
    output timing_t          act,
    output logic             act_valid,
    output logic             first,
    output logic             apply,
    output trig_mode_e       nxt_mode,
    output tick_t            nxt_sub,
    output logic [DIV_W-1:0] nxt_n,
    output logic             err
);
    localparam tick_t MIN_T   = tick_t'(MIN_SUB);
    localparam tick_t OUT_LIM = tick_t'(CALC_TICKS + OUT_HW_TICKS);
    localparam tick_t IN_LIM  = tick_t'(CALC_TICKS + IN_HW_TICKS);
    localparam tick_t OUT_HW  = tick_t'(OUT_HW_TICKS);
    localparam tick_t IN_HW   = tick_t'(IN_HW_TICKS);
    localparam tick_t LEAD_D  = tick_t'(MIN_SUB - IN_LEAD_TICKS);

    timing_t pend, cand;
    logic    pend_q, ok, accept;

    always_comb begin
        ok = (mode_raw != 2'd3) && (sub >= MIN_T) && (n != '0)
           && shift_legal(out_shift, OUT_LIM, OUT_HW, sub)
           && shift_legal(in_shift, IN_LIM, IN_HW, sub);
        cand.mode  = trig_mode_e'(mode_raw);
        cand.sub   = sub;
        cand.n     = n;
        cand.d_out = (out_shift == '0) ? '0 : out_shift - OUT_HW;
        cand.d_in  = (in_shift == '0) ? LEAD_D : in_shift - IN_HW;
        accept     = we && ok;
        first      = accept && !act_valid;
        apply      = first || (bnd && pend_q);
        nxt_mode   = pend_q ? pend.mode : act.mode;
        nxt_sub    = pend_q ? pend.sub  : act.sub;
        nxt_n      = pend_q ? pend.n    : act.n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= '0;
            pend      <= '0;
            pend_q    <= 1'b0;
            act_valid <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (we) err <= !ok;
            if (first) begin
                act       <= cand;
                act_valid <= 1'b1;
            end
            if (bnd && pend_q) begin
                act    <= pend;
                pend_q <= 1'b0;
            end
            if (accept && act_valid) begin
                pend   <= cand;
                pend_q <= 1'b1;
            end
        end
    end

    assert_reject_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !ok) |=> err);
    assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !ok && act_valid && !bnd) |=> $stable(act));
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !bnd) |=> $stable(act.mode));
endmodule

// File: rtl/stu_sched.sv
module stu_sched
    import stu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      lt,
    input  logic [63:0]      start,
    input  logic             act_valid,
    input  trig_mode_e       act_mode,
    input  tick_t            act_sub,
    input  trig_mode_e       nxt_mode,
    input  tick_t            nxt_sub,
    input  logic [DIV_W-1:0] nxt_n,
    input  logic             first,
    input  logic             apply,
    output logic             bnd,
    output logic             cyc_pulse,
    output logic             sub_pulse,
    output logic             fr_pulse
);
    logic [63:0] next_start, sub_next, nxt_period;
    tick_t       fr_cnt;

    assign nxt_period = 64'(nxt_sub) * 64'(nxt_n);
    assign bnd        = act_valid && (lt >= next_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_start <= '0;
            sub_next   <= '0;
            cyc_pulse  <= 1'b0;
            sub_pulse  <= 1'b0;
        end else begin
            cyc_pulse <= 1'b0;
            sub_pulse <= 1'b0;
            if (first) begin
                next_start <= start;
                sub_next   <= start;
            end else if (bnd) begin
                next_start <= next_start + nxt_period;
                sub_next   <= next_start + 64'(nxt_sub);
                if (nxt_mode == MODE_SYNC) begin
                    cyc_pulse <= 1'b1;
                    sub_pulse <= 1'b1;
                end
            end else if (act_valid && act_mode == MODE_SYNC
                         && lt >= sub_next && sub_next < next_start) begin
                sub_pulse <= 1'b1;
                sub_next  <= sub_next + 64'(act_sub);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_cnt   <= '0;
            fr_pulse <= 1'b0;
        end else begin
            fr_pulse <= 1'b0;
            if (apply) begin
                fr_cnt <= '0;
            end else if (act_valid && act_mode == MODE_FREE) begin
                if (fr_cnt == act_sub - 1'b1) begin
                    fr_cnt   <= '0;
                    fr_pulse <= 1'b1;
                end else begin
                    fr_cnt <= fr_cnt + 1'b1;
                end
            end
        end
    end

    assert_cyc_with_sub_R5: assert property (@(posedge clk) disable iff (rst)
        cyc_pulse |-> sub_pulse);
    assert_sub_gap_R5: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |=> !sub_pulse);
endmodule

// File: rtl/sync_trig_unit.sv
module sync_trig_unit
    import stu_pkg::*;
#(
    parameter int MIN_SUB       = 8,
    parameter int CALC_TICKS    = 2,
    parameter int OUT_HW_TICKS  = 3,
    parameter int IN_HW_TICKS   = 2,
    parameter int IN_LEAD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       local_time,
    input  logic              frame_evt,
    input  logic              frame_has_out,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic [TICK_W-1:0] cfg_sub_ticks,
    input  logic [DIV_W-1:0]  cfg_subdiv,
    input  logic [63:0]       cfg_start,
    input  logic [TICK_W-1:0] cfg_out_shift,
    input  logic [TICK_W-1:0] cfg_in_shift,
    output logic              cyc_pulse,
    output logic              sub_pulse,
    output logic              out_strobe,
    output logic              in_strobe,
    output logic              cfg_err
);
    localparam int NCH = 2;

    timing_t          act;
    logic             act_valid, first, apply, bnd, fr_pulse;
    trig_mode_e       nxt_mode;
    tick_t            nxt_sub;
    logic [DIV_W-1:0] nxt_n;
    logic [NCH-1:0]   trig, stb;
    tick_t            dly [NCH];
    logic             out_evt;

    stu_cfg #(
        .MIN_SUB(MIN_SUB), .CALC_TICKS(CALC_TICKS), .OUT_HW_TICKS(OUT_HW_TICKS),
        .IN_HW_TICKS(IN_HW_TICKS), .IN_LEAD_TICKS(IN_LEAD_TICKS)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .mode_raw(cfg_mode), .sub(cfg_sub_ticks),
        .n(cfg_subdiv), .out_shift(cfg_out_shift), .in_shift(cfg_in_shift), .bnd(bnd),
        .act(act), .act_valid(act_valid), .first(first), .apply(apply),
        .nxt_mode(nxt_mode), .nxt_sub(nxt_sub), .nxt_n(nxt_n), .err(cfg_err)
    );

    stu_sched u_sched (
        .clk(clk), .rst(rst), .lt(local_time), .start(cfg_start), .act_valid(act_valid),
        .act_mode(act.mode), .act_sub(act.sub), .nxt_mode(nxt_mode), .nxt_sub(nxt_sub),
        .nxt_n(nxt_n), .first(first), .apply(apply), .bnd(bnd),
        .cyc_pulse(cyc_pulse), .sub_pulse(sub_pulse), .fr_pulse(fr_pulse)
    );

    always_comb begin
        unique case (act.mode)
            MODE_SYNC:  out_evt = sub_pulse;
            MODE_FREE:  out_evt = fr_pulse;
            MODE_FRAME: out_evt = frame_evt && frame_has_out;
            default:    out_evt = 1'b0;
        endcase
        trig[0] = act_valid && out_evt;
        trig[1] = act_valid && (out_evt || (act.mode == MODE_FRAME && frame_evt));
        dly[0]  = act.d_out;
        dly[1]  = act.d_in;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dly
        stu_delay u_dly (.clk(clk), .rst(rst), .trig(trig[g]), .dly(dly[g]), .strobe(stb[g]));
    end

    assign out_strobe = stb[0];
    assign in_strobe  = stb[1];

    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !act_valid |-> !(out_strobe || in_strobe || cyc_pulse || sub_pulse));
endmodule

// File: tb/sim_sync_trig_unit.sv
module sim_sync_trig_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] lt;
    logic        frz = 1'b0;
    int          tk;
    logic        frame_evt = 1'b0, frame_has_out = 1'b0, cfg_we = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [15:0] cfg_sub_ticks = '0, cfg_out_shift = '0, cfg_in_shift = '0;
    logic [3:0]  cfg_subdiv = '0;
    logic [63:0] cfg_start = '0;
    logic        cyc_pulse, sub_pulse, out_strobe, in_strobe, cfg_err;

    int errs = 0, checks = 0;
    int t_cyc[16], t_sub[32], t_out[32], t_in[32];
    int n_cyc, n_sub, n_out, n_in, dbl;
    logic p_out, p_in;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_trig_unit u0 (
        .clk(clk), .rst(rst), .local_time(lt), .frame_evt(frame_evt),
        .frame_has_out(frame_has_out), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_sub_ticks(cfg_sub_ticks), .cfg_subdiv(cfg_subdiv), .cfg_start(cfg_start),
        .cfg_out_shift(cfg_out_shift), .cfg_in_shift(cfg_in_shift),
        .cyc_pulse(cyc_pulse), .sub_pulse(sub_pulse), .out_strobe(out_strobe),
        .in_strobe(in_strobe), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        if (rst) begin lt <= '0; tk <= 0; end
        else begin
            tk <= tk + 1;
            if (!frz) lt <= lt + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc_pulse) begin if (n_cyc < 16) t_cyc[n_cyc] = tk; n_cyc++; end
        if (sub_pulse) begin if (n_sub < 32) t_sub[n_sub] = tk; n_sub++; end
        if (out_strobe) begin if (n_out < 32) t_out[n_out] = tk; n_out++; end
        if (in_strobe) begin if (n_in < 32) t_in[n_in] = tk; n_in++; end
        if ((out_strobe && p_out) || (in_strobe && p_in)) dbl++;
        p_out = out_strobe;
        p_in  = in_strobe;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_reset(input bit freeze);
        rst = 1'b1; frz = freeze; cfg_we = 1'b0; frame_evt = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        n_cyc = 0; n_sub = 0; n_out = 0; n_in = 0; dbl = 0; p_out = 0; p_in = 0;
    endtask

    task automatic wait_tk(input int v);
        while (tk != v) begin @(posedge clk); #1; end
    endtask

    task automatic cfg(input logic [1:0] m, input int sub, input int n, input longint st,
                       input int os, input int is, output int w);
        @(posedge clk); #1;
        cfg_mode = m; cfg_sub_ticks = 16'(sub); cfg_subdiv = 4'(n); cfg_start = 64'(st);
        cfg_out_shift = 16'(os); cfg_in_shift = 16'(is); cfg_we = 1'b1; w = tk;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic frame(input bit has_out);
        frame_evt = 1'b1; frame_has_out = has_out;
        @(posedge clk); #1;
        frame_evt = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk);
        chk_eq("R1 out_strobe after reset", out_strobe, 0);
        chk_eq("R1 cfg_err after reset", cfg_err, 0);
        wait_tk(40);
        chk_eq("R1 no cycle pulses unconfigured", n_cyc, 0);
        chk_eq("R1 no sub pulses unconfigured", n_sub, 0);
        chk_eq("R1 no strobes unconfigured", n_out + n_in, 0);
    endtask

    task automatic t_sync_shift();
        int w;
        do_reset(1'b0);
        wait_tk(5);
        cfg(2'd2, 20, 4, 100, 10, 8, w);
        wait_tk(361);
        chk_eq("R4 first cycle pulse", t_cyc[0], 101);
        chk_eq("R4 second cycle pulse", t_cyc[1], 181);
        chk_eq("R4 cycle spacing no drift", t_cyc[3] - t_cyc[2], 80);
        chk_eq("R4 cycle count", n_cyc, 4);
        chk_eq("R5 sub pulse count", n_sub, 13);
        chk_eq("R5 sub spacing", t_sub[1] - t_sub[0], 20);
        chk_eq("R5 fifth sub aligns with cycle", t_sub[4], 181);
        chk_eq("R6 first output strobe", t_out[0], 109);
        chk_eq("R6 output strobe count", n_out, 13);
        chk_eq("R7 first input strobe", t_in[0], 108);
        chk_eq("R7 input strobe spacing", t_in[5] - t_in[4], 20);
        chk_eq("R12 single-cycle strobes", dbl, 0);
    endtask

    task automatic t_noshift();
        int w;
        do_reset(1'b0);
        wait_tk(5);
        cfg(2'd2, 10, 2, 50, 0, 0, w);
        wait_tk(81);
        chk_eq("R8 immediate output strobe", t_out[0], 52);
        chk_eq("R8 lead-based input strobe", t_in[0], 57);
        chk_eq("R8 input strobe count", n_in, 3);
    endtask

    task automatic t_reject();
        int w;
        do_reset(1'b0);
        wait_tk(5);
        cfg(2'd2, 20, 4, 40, 0, 0, w);
        wait_tk(45);
        cfg(2'd2, 4, 4, 40, 0, 0, w);  @(negedge clk);
        chk_eq("R2 short sub period rejected", cfg_err, 1);
        cfg(2'd2, 20, 0, 40, 0, 0, w); @(negedge clk);
        chk_eq("R2 zero subdivision rejected", cfg_err, 1);
        cfg(2'd3, 20, 4, 40, 0, 0, w); @(negedge clk);
        chk_eq("R2 mode 3 rejected", cfg_err, 1);
        cfg(2'd2, 20, 4, 40, 5, 0, w); @(negedge clk);
        chk_eq("R3 output shift at limit rejected", cfg_err, 1);
        cfg(2'd2, 20, 4, 40, 23, 0, w); @(negedge clk);
        chk_eq("R3 output shift beyond period rejected", cfg_err, 1);
        cfg(2'd2, 20, 4, 40, 0, 4, w); @(negedge clk);
        chk_eq("R3 input shift at limit rejected", cfg_err, 1);
        wait_tk(200);
        chk_eq("R2 timing kept: sub count", n_sub, 8);
        chk_eq("R2 timing kept: last sub", t_sub[7], 181);
        cfg(2'd2, 20, 4, 40, 10, 8, w); @(negedge clk);
        chk_eq("R2 accepted write clears error", cfg_err, 0);
    endtask

    task automatic t_frame();
        int w;
        do_reset(1'b0);
        wait_tk(5);
        cfg(2'd1, 20, 1, 5000, 10, 8, w);
        wait_tk(30); frame(1'b1);
        wait_tk(60); frame(1'b0);
        wait_tk(90);
        chk_eq("R9 output frame gives one output strobe", n_out, 1);
        chk_eq("R9 output strobe time", t_out[0], 38);
        chk_eq("R9 both frames latch input", n_in, 2);
        chk_eq("R9 input strobe after output frame", t_in[0], 37);
        chk_eq("R9 input strobe after input-only frame", t_in[1], 67);
        chk_eq("R9 no sub pulses in frame mode", n_sub, 0);
    endtask

    task automatic t_freerun();
        int w;
        do_reset(1'b1);
        wait_tk(5);
        cfg(2'd0, 12, 1, 5000, 0, 0, w);
        wait_tk(w + 80);
        chk_eq("R10 first free-run output strobe", t_out[0], w + 14);
        chk_eq("R10 free-run period", t_out[2] - t_out[1], 12);
        chk_eq("R10 free-run strobe count", n_out, 6);
        chk_eq("R10 first free-run input strobe", t_in[0], w + 19);
        chk_eq("R10 no cycle pulses", n_cyc, 0);
    endtask

    task automatic t_modechg();
        int w;
        do_reset(1'b0);
        wait_tk(5);
        cfg(2'd2, 20, 2, 60, 0, 0, w);
        wait_tk(69);
        cfg(2'd1, 20, 2, 60, 0, 0, w);
        wait_tk(90); frame(1'b1);
        wait_tk(110); frame(1'b1);
        wait_tk(131);
        chk_eq("R11 sub pulses only before boundary", n_sub, 2);
        chk_eq("R11 single cycle pulse", n_cyc, 1);
        chk_eq("R11 old mode keeps control", t_out[1], 82);
        chk_eq("R11 early frame ignored", n_out, 3);
        chk_eq("R11 frame after boundary", t_out[2], 111);
        chk_eq("R11 input strobe after boundary frame", t_in[2], 116);
        chk_eq("R12 single-cycle strobes", dbl, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sync_shift();
        t_noshift();
        t_reject();
        t_frame();
        t_freerun();
        t_modechg();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule